// File: doc/BRIEF.md
# SDRAM Command and Timing Sequencer

This block sits between a simple host request port and the command pins of a single-rank memory module with four internal banks. Each accepted host request names a row, a bank, a column and a direction. The block opens that row with an activate command. It then issues one read or write with auto-precharge, so the bank closes by itself and no separate precharge command is ever needed. Every minimum spacing between commands is counted in clocks. The spacing values and the refresh interval are parameters fixed when the design is built.

After reset the block writes the mode register exactly once, then waits for requests. A free-running interval counter marks a refresh as due. A due refresh is served ahead of any new host request as soon as every bank has closed and all write recovery has elapsed. The counter keeps running while the refresh waits, so later refreshes stay on the same schedule. The host sees a valid/ready handshake, and `done` pulses in the cycle when the column command of its request appears on the bus.

Top module: `sdram_cmd_seq`

## Requirements
- R1: While reset is held, the bus carries a no-op and clock enable is high. After reset the first command is a single mode-register write carrying `MODE_WORD` on `addr`. No other command follows it for `T_MRD` clocks.
- R2: Commands are encoded on {cs_n, ras_n, cas_n, we_n} as follows: no-op 0111, activate 0011, read 0101, write 0100, auto refresh 0001, mode-register write 0000.
- R3: The host address is {row[11:0], bank[1:0], col[10:0]}, most significant field first. Each accepted request produces one activate that carries its bank on `ba` and its row on `addr`, and activates appear in the order the requests were accepted.
- R4: The column command for a request carries col[9:0] on addr[9:0], col[10] on addr[11], and a 1 on addr[10] to request auto-precharge. It is a write when the request's write flag was 1 and a read otherwise.
- R5: A column command comes at least `T_RCD` clocks after the activate of its bank.
- R6: Two activates are at least `T_RRD` clocks apart in any banks, and at least `T_RC` clocks apart in the same bank.
- R7: An activate comes at least `T_DAL` clocks after the most recent write.
- R8: A refresh is issued only when every bank is at least `T_RC` clocks past its last activate and at least `T_DAL` clocks past the last write. No command follows a refresh for `T_RFC` clocks.
- R9: The number of refreshes issued in a run equals the elapsed clocks divided by `T_REFI`, within one.
- R10: A due refresh takes priority over waiting host requests. Under continuous host load, consecutive refreshes are still `T_REFI` apart within a slack of 12 clocks.
- R11: `done` is high for exactly the cycles in which a column command is on the bus. `req_ready` is low during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Host request is present |
| req_ready | output | 1 | Request is accepted on this edge if valid |
| req_write | input | 1 | 1 = write request, 0 = read request |
| req_addr | input | 25 | {row, bank, col} of the request |
| done | output | 1 | Column command of a request is on the bus |
| cke | output | 1 | Clock enable, held high |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | 2 | Bank address |
| addr | output | 12 | Row, column or mode word |

## Verification
A refresh coming due and a new host request being ready to open a row can land in the same idle cycle. The bench provokes this collision by keeping a request waiting at every moment, first in a sweep over banks, directions and same-bank runs, and then in a long back-to-back burst. The outcome is judged only at the pins. Each refresh must fall inside its interval window and must find every bank closed. The activate that follows a refresh must respect the refresh cycle time, and no request may be lost or reordered.

// File: rtl/sdram_seq_pkg.sv
// Shared types for the SDRAM command sequencer.
// Command codes are the {cs_n, ras_n, cas_n, we_n} pin pattern.
package sdram_seq_pkg;
    typedef enum logic [3:0] {
        CMD_MRS = 4'b0000,
        CMD_REF = 4'b0001,
        CMD_ACT = 4'b0011,
        CMD_WR  = 4'b0100,
        CMD_RD  = 4'b0101,
        CMD_NOP = 4'b0111
    } cmd_e;

    typedef enum logic [1:0] {
        ST_INIT,
        ST_IDLE,
        ST_COL
    } seq_state_e;
endpackage

// File: rtl/sdram_refresh_timer.sv
// Free-running refresh interval counter.
// Raises 'pending' each time T_REFI clocks elapse; 'ack' clears it.
// Assumes T_REFI >= 2. The count never pauses for a waiting refresh.
module sdram_refresh_timer #(
    parameter int T_REFI = 1563
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ack,
    output logic pending
);
    localparam int CW = $clog2(T_REFI);

    logic [CW-1:0] cnt;
    logic          wrap;

    assign wrap = (cnt == CW'(T_REFI - 1));

    // Interval counter wraps every T_REFI clocks.
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt <= '0;
        else if (wrap) cnt <= '0;
        else           cnt <= cnt + 1'b1;
    end

    // Pending flag: set on wrap (wins over ack), cleared on ack.
    always_ff @(posedge clk) begin
        if (!rst_n)    pending <= 1'b0;
        else if (wrap) pending <= 1'b1;
        else if (ack)  pending <= 1'b0;
    end
endmodule

// File: rtl/sdram_bank_timers.sv
// One row-cycle countdown per bank.
// A load on activate starts the bank's T_RC window; 'closed' is high once the
// window has run out. Auto-precharge is assumed to finish inside T_RC.
module sdram_bank_timers #(
    parameter int NBANK = 4,
    parameter int T_RC  = 7,
    parameter int TW    = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     load,
    input  logic [$clog2(NBANK)-1:0] load_bank,
    output logic [NBANK-1:0]         closed
);
    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        logic [TW-1:0] cnt;

        // Per-bank countdown from T_RC-1 to zero.
        always_ff @(posedge clk) begin
            if (!rst_n)                            cnt <= '0;
            else if (load && load_bank == b[$clog2(NBANK)-1:0]) cnt <= TW'(T_RC - 1);
            else if (cnt != '0)                    cnt <= cnt - 1'b1;
        end

        assign closed[b] = (cnt == '0);
    end
endmodule

// File: rtl/sdram_cmd_seq.sv
// SDRAM command and timing sequencer (top).
// Turns host read/write requests into activate + column-with-auto-precharge
// pairs, inserts periodic auto refresh, and writes the mode register once
// after reset. All spacings are parameters in clocks. Assumes one request in
// flight, burst length 1, and COL_W + 1 <= ROW_W (column skips the flag line).
module sdram_cmd_seq
    import sdram_seq_pkg::*;
#(
    parameter int          ROW_W     = 12,
    parameter int          BANK_W    = 2,
    parameter int          COL_W     = 11,
    parameter int          T_RCD     = 2,
    parameter int          T_RRD     = 2,
    parameter int          T_RC      = 7,
    parameter int          T_MRD     = 2,
    parameter int          T_RFC     = 7,
    parameter int          T_DAL     = 2,
    parameter int          T_REFI    = 1563,
    parameter logic [11:0] MODE_WORD = 12'h020
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            req_valid,
    output logic                            req_ready,
    input  logic                            req_write,
    input  logic [ROW_W+BANK_W+COL_W-1:0]   req_addr,
    output logic                            done,
    output logic                            cke,
    output logic                            cs_n,
    output logic                            ras_n,
    output logic                            cas_n,
    output logic                            we_n,
    output logic [BANK_W-1:0]               ba,
    output logic [ROW_W-1:0]                addr
);
    localparam int NBANK  = 1 << BANK_W;
    localparam int AP_BIT = 10;
    localparam int TMAX   = T_RC + T_RFC + T_MRD + T_DAL + T_RCD + T_RRD;
    localparam int TW     = $clog2(TMAX + 1);

    seq_state_e        state;
    cmd_e              cmd_q;
    logic [TW-1:0]     gap, rrd, dal;
    logic [BANK_W-1:0] hold_bank;
    logic [COL_W-1:0]  hold_col;
    logic              hold_wr;
    logic [NBANK-1:0]  bank_closed;
    logic              ref_pending, ref_go, accept;

    logic [COL_W-1:0]  in_col;
    logic [BANK_W-1:0] in_bank;
    logic [ROW_W-1:0]  in_row;

    assign in_col  = req_addr[COL_W-1:0];
    assign in_bank = req_addr[COL_W +: BANK_W];
    assign in_row  = req_addr[COL_W+BANK_W +: ROW_W];

    // Column onto the bus with the auto-precharge line forced high.
    function automatic logic [ROW_W-1:0] col_bus(input logic [COL_W-1:0] c);
        logic [ROW_W-1:0] a;
        a = '0;
        for (int i = 0; i < COL_W; i++) begin
            if (i < AP_BIT) a[i]     = c[i];
            else            a[i + 1] = c[i];
        end
        a[AP_BIT] = 1'b1;
        return a;
    endfunction

    // Refresh when due, nothing else pending and every bank closed.
    assign ref_go = (state == ST_IDLE) && ref_pending && (gap == '0) &&
                    (dal == '0) && (&bank_closed);

    // Host may start a row only when all spacings to an activate are met.
    assign req_ready = (state == ST_IDLE) && !ref_pending && (gap == '0) &&
                       (rrd == '0) && (dal == '0) && bank_closed[in_bank];
    assign accept    = req_valid && req_ready;

    sdram_refresh_timer #(.T_REFI(T_REFI)) u_refi (
        .clk     (clk),
        .rst_n   (rst_n),
        .ack     (ref_go),
        .pending (ref_pending)
    );

    sdram_bank_timers #(.NBANK(NBANK), .T_RC(T_RC), .TW(TW)) u_banks (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (accept),
        .load_bank (in_bank),
        .closed    (bank_closed)
    );

    // Sequencer: picks one command per clock and loads the spacing counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_INIT;
            cmd_q     <= CMD_NOP;
            gap       <= '0;
            rrd       <= '0;
            dal       <= '0;
            ba        <= '0;
            addr      <= '0;
            done      <= 1'b0;
            hold_bank <= '0;
            hold_col  <= '0;
            hold_wr   <= 1'b0;
        end else begin
            cmd_q <= CMD_NOP;
            done  <= 1'b0;
            gap   <= (gap != '0) ? gap - 1'b1 : gap;
            rrd   <= (rrd != '0) ? rrd - 1'b1 : rrd;
            dal   <= (dal != '0) ? dal - 1'b1 : dal;
            unique case (state)
                ST_INIT: begin
                    cmd_q <= CMD_MRS;
                    ba    <= '0;
                    addr  <= MODE_WORD;
                    gap   <= TW'(T_MRD - 1);
                    state <= ST_IDLE;
                end
                ST_IDLE: begin
                    if (ref_go) begin
                        cmd_q <= CMD_REF;
                        gap   <= TW'(T_RFC - 1);
                    end else if (accept) begin
                        cmd_q     <= CMD_ACT;
                        ba        <= in_bank;
                        addr      <= in_row;
                        gap       <= TW'(T_RCD - 1);
                        rrd       <= TW'(T_RRD - 1);
                        hold_bank <= in_bank;
                        hold_col  <= in_col;
                        hold_wr   <= req_write;
                        state     <= ST_COL;
                    end
                end
                ST_COL: begin
                    if (gap == '0) begin
                        cmd_q <= hold_wr ? CMD_WR : CMD_RD;
                        ba    <= hold_bank;
                        addr  <= col_bus(hold_col);
                        done  <= 1'b1;
                        if (hold_wr) dal <= TW'(T_DAL - 1);
                        state <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign cke   = 1'b1;
    assign cs_n  = cmd_q[3];
    assign ras_n = cmd_q[2];
    assign cas_n = cmd_q[1];
    assign we_n  = cmd_q[0];
endmodule

// File: rtl/sdram_cmd_seq_chk.sv
// Pin-level timing checker for sdram_cmd_seq, bound to every instance.
// Tracks clocks since the last command of each kind with saturating counters.
module sdram_cmd_seq_chk #(
    parameter int T_RCD = 2,
    parameter int T_RRD = 2,
    parameter int T_RC  = 7,
    parameter int T_MRD = 2,
    parameter int T_RFC = 7,
    parameter int T_DAL = 2
) (
    input logic        clk,
    input logic        rst_n,
    input logic        cs_n,
    input logic        ras_n,
    input logic        cas_n,
    input logic        we_n,
    input logic        addr_ap,
    input logic        done
);
    logic [3:0] c;
    logic [7:0] s_act, s_wr, s_ref, s_mrs;
    logic       is_act, is_col, is_ref, is_mrs, is_cmd;

    assign c      = {cs_n, ras_n, cas_n, we_n};
    assign is_act = (c == 4'b0011);
    assign is_col = (c == 4'b0101) || (c == 4'b0100);
    assign is_ref = (c == 4'b0001);
    assign is_mrs = (c == 4'b0000);
    assign is_cmd = (c != 4'b0111);

    function automatic logic [7:0] bump(input logic [7:0] v);
        return (v == 8'hFF) ? v : v + 8'd1;
    endfunction

    // Clocks since last activate / write / refresh / mode write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_act <= 8'hFF; s_wr <= 8'hFF; s_ref <= 8'hFF; s_mrs <= 8'hFF;
        end else begin
            s_act <= is_act ? 8'd1 : bump(s_act);
            s_wr  <= (c == 4'b0100) ? 8'd1 : bump(s_wr);
            s_ref <= is_ref ? 8'd1 : bump(s_ref);
            s_mrs <= is_mrs ? 8'd1 : bump(s_mrs);
        end
    end

    AST_ACT_SPACING:  assert property (@(posedge clk) disable iff (!rst_n) is_act |-> s_act >= 8'(T_RRD)); // R6
    AST_COL_AFTER_ACT: assert property (@(posedge clk) disable iff (!rst_n) is_col |-> s_act >= 8'(T_RCD)); // R5
    AST_WRITE_RECOVER: assert property (@(posedge clk) disable iff (!rst_n) is_act |-> s_wr >= 8'(T_DAL)); // R7
    AST_REF_QUIET:    assert property (@(posedge clk) disable iff (!rst_n) is_ref |-> (s_act >= 8'(T_RC) && s_wr >= 8'(T_DAL))); // R8
    AST_AFTER_REF:    assert property (@(posedge clk) disable iff (!rst_n) is_cmd |-> s_ref >= 8'(T_RFC)); // R8
    AST_AFTER_MRS:    assert property (@(posedge clk) disable iff (!rst_n) is_cmd |-> s_mrs >= 8'(T_MRD)); // R1
    AST_AP_SET:       assert property (@(posedge clk) disable iff (!rst_n) is_col |-> addr_ap); // R4
    AST_DONE_WITH_COL: assert property (@(posedge clk) disable iff (!rst_n) done == is_col); // R11
endmodule

bind sdram_cmd_seq sdram_cmd_seq_chk #(
    .T_RCD(T_RCD), .T_RRD(T_RRD), .T_RC(T_RC),
    .T_MRD(T_MRD), .T_RFC(T_RFC), .T_DAL(T_DAL)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .addr_ap(addr[10]), .done(done)
);

// File: tb/sdram_cmd_seq_tb.sv
// Self-checking bench: decodes every bus command, checks each spacing rule,
// the fields carried, the refresh schedule, and the request order.
module sdram_cmd_seq_tb;
    localparam int T_RCD = 2, T_RRD = 2, T_RC = 7, T_MRD = 2;
    localparam int T_RFC = 7, T_DAL = 2, T_REFI = 60, SLACK = 12;
    localparam logic [11:0] MODE = 12'h032;

    localparam logic [3:0] C_NOP = 4'b0111, C_ACT = 4'b0011, C_RD = 4'b0101;
    localparam logic [3:0] C_WR  = 4'b0100, C_REF = 4'b0001, C_MRS = 4'b0000;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [24:0] req_addr = '0;
    logic        req_ready, done, cke, cs_n, ras_n, cas_n, we_n;
    logic [1:0]  ba;
    logic [11:0] addr;

    int checks = 0, errors = 0;
    int cyc = 0, t0 = 0, n_req = 0, act_i = 0, col_i = 0, n_ref = 0;
    int last_any_act = -1000, last_wr = -1000, last_ref = -1000, last_mrs = -1000;
    int last_act [4];
    logic [24:0] q_addr [256];
    logic        q_wr   [256];
    logic        seen_first = 1'b0, running = 1'b0;

    always #5 clk = ~clk;

    sdram_cmd_seq #(
        .T_RCD(T_RCD), .T_RRD(T_RRD), .T_RC(T_RC), .T_MRD(T_MRD),
        .T_RFC(T_RFC), .T_DAL(T_DAL), .T_REFI(T_REFI), .MODE_WORD(MODE)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .done(done), .cke(cke),
        .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr)
    );

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s at cycle %0d: actual %0d expected %0d", tag, cyc, act, exp);
        end
    endtask

    // Monitor: decodes the bus between edges and checks every rule.
    always @(negedge clk) begin
        logic [3:0] c;
        c = {cs_n, ras_n, cas_n, we_n};
        if (!rst_n) begin
            chk(c == C_NOP && cke && !req_ready && !done, "R1 reset state", int'(c), int'(C_NOP));
        end else begin
            cyc++;
            if (c != C_NOP) begin
                chk(cyc - last_mrs >= T_MRD, "R1 mode-write spacing", cyc - last_mrs, T_MRD);
                chk(cyc - last_ref >= T_RFC, "R8 refresh-to-command", cyc - last_ref, T_RFC);
            end
            if (c != C_NOP && !seen_first) begin
                seen_first = 1'b1;
                chk(c == C_MRS, "R1 first command is mode write", int'(c), int'(C_MRS));
                chk(addr == MODE, "R1 mode word", int'(addr), int'(MODE));
            end else if (c == C_MRS) begin
                chk(1'b0, "R1 second mode write", cyc, 0);
            end
            chk(done == (c == C_RD || c == C_WR), "R11 done with column", int'(done), int'(c == C_RD || c == C_WR));
            case (c)
                C_MRS: last_mrs = cyc;
                C_ACT: begin
                    chk(act_i < n_req, "R3 activate without request", act_i, n_req);
                    chk(ba == q_addr[act_i][12:11], "R3 activate bank", int'(ba), int'(q_addr[act_i][12:11]));
                    chk(addr == q_addr[act_i][24:13], "R3 activate row", int'(addr), int'(q_addr[act_i][24:13]));
                    chk(cyc - last_any_act >= T_RRD, "R6 any-bank spacing", cyc - last_any_act, T_RRD);
                    chk(cyc - last_act[ba] >= T_RC, "R6 same-bank spacing", cyc - last_act[ba], T_RC);
                    chk(cyc - last_wr >= T_DAL, "R7 write-to-activate", cyc - last_wr, T_DAL);
                    last_any_act = cyc;
                    last_act[ba] = cyc;
                    act_i++;
                end
                C_RD, C_WR: begin
                    logic [10:0] cl;
                    logic [11:0] eb;
                    cl = q_addr[col_i][10:0];
                    eb = {cl[10], 1'b1, cl[9:0]};
                    chk(col_i < act_i, "R4 column without activate", col_i, act_i);
                    chk((c == C_WR) == q_wr[col_i], "R4 direction", int'(c == C_WR), int'(q_wr[col_i]));
                    chk(addr == eb, "R4 column bits and precharge flag", int'(addr), int'(eb));
                    chk(ba == q_addr[col_i][12:11], "R4 column bank", int'(ba), int'(q_addr[col_i][12:11]));
                    chk(cyc - last_act[ba] >= T_RCD, "R5 activate-to-column", cyc - last_act[ba], T_RCD);
                    if (c == C_WR) last_wr = cyc;
                    col_i++;
                end
                C_REF: begin
                    for (int b = 0; b < 4; b++)
                        chk(cyc - last_act[b] >= T_RC, "R8 refresh with bank open", cyc - last_act[b], T_RC);
                    chk(cyc - last_wr >= T_DAL, "R8 refresh after write", cyc - last_wr, T_DAL);
                    if (n_ref > 0) begin
                        chk(cyc - last_ref >= T_REFI - SLACK && cyc - last_ref <= T_REFI + SLACK,
                            "R10 refresh interval", cyc - last_ref, T_REFI);
                    end else begin
                        chk(cyc <= T_REFI + SLACK, "R10 first refresh", cyc, T_REFI);
                    end
                    n_ref++;
                    last_ref = cyc;
                end
                C_NOP: ;
                default: chk(1'b0, "R2 unknown command code", int'(c), int'(C_NOP));
            endcase
        end
    end

    task automatic request(input logic w, input logic [11:0] row, input logic [1:0] bk,
                           input logic [10:0] col);
        @(negedge clk);
        req_valid = 1'b1;
        req_write = w;
        req_addr  = {row, bk, col};
        #1;
        while (!req_ready) begin
            @(negedge clk);
            #1;
        end
        q_addr[n_req] = req_addr;
        q_wr[n_req]   = w;
        n_req++;
        @(posedge clk);
        #1;
        req_valid = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired: actual %0d expected %0d", cyc, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int b = 0; b < 4; b++) last_act[b] = -1000;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // Sweep: bank, direction, bank rotation (different-bank spacing, R6).
        for (int b = 0; b < 4; b++)
            for (int w = 0; w < 2; w++)
                for (int k = 0; k < 4; k++)
                    request(w[0], 12'((b * 4 + k) * 37 + 5), 2'((b + k) % 4),
                            11'((w * 4 + k) * 91 + 3 + b * 256));
        // Same-bank run: row cycle limits and write recovery (R6, R7).
        for (int k = 0; k < 16; k++)
            request(k[0], 12'(k * 255), 2'd2, 11'(2047 - k * 129));
        // Idle: refresh alone keeps its schedule (R9).
        repeat (200) @(negedge clk);
        // Continuous load: refresh collides with waiting requests (R10).
        for (int k = 0; k < 60; k++)
            request(k[1] ^ k[0], 12'(4095 - k * 61), 2'(k % 3), 11'(k * 34 + 1024));
        repeat (30) @(negedge clk);
        chk(act_i == n_req, "R3 every request activated", act_i, n_req);
        chk(col_i == n_req, "R4 every request got a column command", col_i, n_req);
        chk(n_ref - cyc / T_REFI <= 1 && cyc / T_REFI - n_ref <= 1,
            "R9 refresh count", n_ref, cyc / T_REFI);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule